// File: doc/BRIEF.md
# Nibble-Configurable Bidirectional I/O Port

This block is an 8-bit general-purpose I/O port for a small microcontroller core. Software reaches it through a register-file bus. One data register holds the port value. One control register sets the function of each 4-bit half of the port and the open-drain option. Neither register needs a special access operation: plain register reads and writes do everything.

Each nibble works in one of three ways:
- **Input:** pins are sampled through a two-flop synchronizer, and reads of those bits return the sampled value.
- **Output:** the pins are driven from a private output register.
- **Address:** the pins carry the matching bits of an external address bus.

Input and output storage are kept separate. A write to input bits is held out of sight until software switches those bits to output. This lets software preset the value before the drivers turn on. When the open-drain option is set, output nibbles stop driving ones and only pull low.

Top module: `gpio_nibble_port`

## Requirements
- R1: After synchronous reset:
  - every output enable is low;
  - the output register is 0x00;
  - both nibbles are in input mode with open-drain off, so a control read returns 0x05;
  - the read data bus is 0x00.
- R2: Control register layout:
  - bits [1:0] set the low nibble and bits [3:2] set the high nibble, with 00 = output, 01 = input, 10 or 11 = address;
  - bit 4 enables open-drain;
  - bits [7:5] read back as 0;
  - each nibble follows its own field independently.
- R3: For an output nibble with open-drain off, pins are driven from the output register with output enable high. Both take effect on the clock edge after the register update, not the same edge.
- R4: A data write to bits in input mode is stored in the output register. The pins stay undriven, and a data read of those bits returns the synchronized pin input, not the stored value.
- R5: When input bits are switched to output, the previously written value appears on the pins and becomes readable from the data register.
- R6: A pin change reaches the read data bus on the third rising edge after it occurs: two synchronizer stages plus the registered read. The read data bus is registered from the address presented one edge earlier.
- R7: For an output nibble with open-drain on:
  - a 0 bit drives low with output enable high;
  - a 1 bit has its output enable low;
  - the data read returns the output register value.
- R8: An address nibble drives its pins from the matching address-bus bits one edge later with output enable high, whatever the open-drain setting. A data read returns the driven address value.
- R9: Register addresses:
  - the data register sits at 0x00 and the control register at 0xF8;
  - reads of any other address return 0x00;
  - writes to other addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_addr | input | 8 | Register-file address, used for both reads and writes |
| rf_we | input | 1 | Write strobe |
| rf_wdata | input | 8 | Write data |
| rf_rdata | output | 8 | Registered read data for the address of the previous cycle |
| pad_out | output | 8 | Pin drive value |
| pad_oe | output | 8 | Pin output enable, active high |
| pad_in | input | 8 | Asynchronous pin input value |
| abus | input | 8 | Address bits driven by nibbles in address mode |

## Verification
The bench builds the block with its default parameters:
- an 8-bit port split into two 4-bit nibbles;
- a two-stage synchronizer;
- the data register at 0x00 and the control register at 0xF8.

With two nibbles, the bench can mix modes, for example one nibble in input and the other in output. It then checks that each half follows its own field. It also walks the input-to-output preset path, the exact three-edge input latency, open-drain masking, and address pass-through with open-drain set.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    NMODE_OUT  = 2'b00,
    NMODE_IN   = 2'b01,
    NMODE_ADR  = 2'b10,
    NMODE_ADR2 = 2'b11
  } nib_mode_e;

  localparam int unsigned MODE_FIELD_W = 2;

  function automatic logic is_addr_mode(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_nibble.sv
module gpio_nibble
  import gpio_port_pkg::*;
#(
  parameter int unsigned NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          od_en,
  input  logic [NW-1:0] out_bits,
  input  logic [NW-1:0] adr_bits,
  input  logic [NW-1:0] sync_bits,
  output logic [NW-1:0] drive_q,
  output logic [NW-1:0] oe_q,
  output logic [NW-1:0] rd_bits
);
  logic [NW-1:0] drive_d;
  logic [NW-1:0] oe_d;

  always_comb begin
    drive_d = is_addr_mode(mode) ? adr_bits : out_bits;
    unique case (nib_mode_e'(mode))
      NMODE_OUT: oe_d = od_en ? ~out_bits : '1;
      NMODE_IN:  oe_d = '0;
      default:   oe_d = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= '0;
      oe_q    <= '0;
    end else begin
      drive_q <= drive_d;
      oe_q    <= oe_d;
    end
  end

  assign rd_bits = (nib_mode_e'(mode) == NMODE_IN) ? sync_bits : drive_q;
endmodule

// File: rtl/gpio_nibble_port.sv
module gpio_nibble_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned NIB_W       = 4,
  parameter int unsigned RF_AW       = 8,
  parameter logic [7:0]  DATA_ADDR   = 8'h00,
  parameter logic [7:0]  MODE_ADDR   = 8'hF8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RF_AW-1:0]  rf_addr,
  input  logic              rf_we,
  input  logic [PORT_W-1:0] rf_wdata,
  output logic [PORT_W-1:0] rf_rdata,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  input  logic [PORT_W-1:0] pad_in,
  input  logic [PORT_W-1:0] abus
);
  localparam int unsigned NIBS   = PORT_W / NIB_W;
  localparam int unsigned MODE_W = MODE_FIELD_W * NIBS + 1;
  localparam int unsigned OD_BIT = MODE_FIELD_W * NIBS;

  function automatic logic [MODE_W-1:0] mode_reset();
    logic [MODE_W-1:0] v;
    v = '0;
    for (int n = 0; n < NIBS; n++) v[n*MODE_FIELD_W +: MODE_FIELD_W] = NMODE_IN;
    return v;
  endfunction

  logic [MODE_W-1:0] mode_q;
  logic [PORT_W-1:0] out_q;
  logic [PORT_W-1:0] sync_in;
  logic [PORT_W-1:0] port_rd;
  logic [PORT_W-1:0] mode_rd;
  logic [PORT_W-1:0] rd_next;
  logic              hit_data;
  logic              hit_mode;

  assign hit_data = (rf_addr == RF_AW'(DATA_ADDR));
  assign hit_mode = (rf_addr == RF_AW'(MODE_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode_reset();
      out_q  <= '0;
    end else if (rf_we) begin
      if (hit_mode) mode_q <= rf_wdata[MODE_W-1:0];
      if (hit_data) out_q  <= rf_wdata;
    end
  end

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (sync_in)
  );

  generate
    for (genvar n = 0; n < NIBS; n++) begin : g_nib
      gpio_nibble #(.NW(NIB_W)) u_nib (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q[n*MODE_FIELD_W +: MODE_FIELD_W]),
        .od_en     (mode_q[OD_BIT]),
        .out_bits  (out_q[n*NIB_W +: NIB_W]),
        .adr_bits  (abus[n*NIB_W +: NIB_W]),
        .sync_bits (sync_in[n*NIB_W +: NIB_W]),
        .drive_q   (pad_out[n*NIB_W +: NIB_W]),
        .oe_q      (pad_oe[n*NIB_W +: NIB_W]),
        .rd_bits   (port_rd[n*NIB_W +: NIB_W])
      );
    end
  endgenerate

  always_comb begin
    mode_rd = '0;
    mode_rd[MODE_W-1:0] = mode_q;
    if (hit_data)      rd_next = port_rd;
    else if (hit_mode) rd_next = mode_rd;
    else               rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rf_rdata <= '0;
    else     rf_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_nibble_port_chk.sv
module gpio_nibble_port_chk #(
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned NIB_W     = 4,
  parameter int unsigned RF_AW     = 8,
  parameter int unsigned MODE_W    = 5,
  parameter logic [7:0]  MODE_ADDR = 8'hF8
) (
  input logic              clk,
  input logic              rst,
  input logic [RF_AW-1:0]  rf_addr,
  input logic [PORT_W-1:0] rf_rdata,
  input logic [PORT_W-1:0] pad_out,
  input logic [PORT_W-1:0] pad_oe,
  input logic [PORT_W-1:0] abus,
  input logic [MODE_W-1:0] mode_q,
  input logic [PORT_W-1:0] out_q
);
  localparam int unsigned NIBS   = PORT_W / NIB_W;
  localparam int unsigned OD_BIT = 2 * NIBS;

  logic [PORT_W-1:0] mode_ext;
  always_comb begin
    mode_ext = '0;
    mode_ext[MODE_W-1:0] = mode_q;
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && rf_rdata == '0));

  // R2
  a_r2_mode_readback: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rf_addr == RF_AW'(MODE_ADDR))) |-> rf_rdata == $past(mode_ext));

  generate
    for (genvar n = 0; n < NIBS; n++) begin : g_chk
      // R3
      a_r3_out_drive: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_q[2*n +: 2] == 2'b00 && !mode_q[OD_BIT]))
        |-> (pad_oe[n*NIB_W +: NIB_W] == '1 &&
             pad_out[n*NIB_W +: NIB_W] == $past(out_q[n*NIB_W +: NIB_W])));
      // R4
      a_r4_input_undriven: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_q[2*n +: 2] == 2'b01))
        |-> pad_oe[n*NIB_W +: NIB_W] == '0);
      // R7
      a_r7_open_drain: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_q[2*n +: 2] == 2'b00 && mode_q[OD_BIT]))
        |-> (pad_oe[n*NIB_W +: NIB_W] == ~$past(out_q[n*NIB_W +: NIB_W])));
      // R8
      a_r8_addr_follow: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_q[2*n + 1]))
        |-> (pad_oe[n*NIB_W +: NIB_W] == '1 &&
             pad_out[n*NIB_W +: NIB_W] == $past(abus[n*NIB_W +: NIB_W])));
    end
  endgenerate
endmodule

bind gpio_nibble_port gpio_nibble_port_chk #(
  .PORT_W    (PORT_W),
  .NIB_W     (NIB_W),
  .RF_AW     (RF_AW),
  .MODE_W    (MODE_W),
  .MODE_ADDR (MODE_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rf_addr  (rf_addr),
  .rf_rdata (rf_rdata),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .abus     (abus),
  .mode_q   (mode_q),
  .out_q    (out_q)
);

// File: tb/sim_gpio_nibble_port.sv
module sim_gpio_nibble_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rf_addr = 8'h00;
  logic       rf_we = 1'b0;
  logic [7:0] rf_wdata = 8'h00;
  logic [7:0] rf_rdata;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] abus = 8'h00;

  always #10 clk = ~clk;

  gpio_nibble_port u0 (
    .clk(clk), .rst(rst), .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata), .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in), .abus(abus)
  );

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit reported = 0;

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  task automatic expect_sig(input int sel, input logic [7:0] exp, input string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    rf_addr = a; rf_we = 1'b1; rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0; rf_addr = 8'h00;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [7:0] exp, input string req);
    rf_addr = a;
    @(negedge clk);
    expect_sig(0, exp, req);
    rf_addr = 8'h00;
    @(negedge clk);
  endtask

  // Monitor: pops expected items and compares against the observed outputs.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.sel)
          0:       act = rf_rdata;
          1:       act = pad_out;
          default: act = pad_oe;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    settle(4);
    expect_sig(2, 8'h00, "R1 oe low");
    expect_sig(0, 8'h00, "R1 rdata zero");
    rst = 1'b0;
    settle(1);
    rd_expect(8'hF8, 8'h05, "R1 control reset");

    // R4: write while input is hidden
    pad_in = 8'hA5;
    wr(8'h00, 8'h3C);
    settle(3);
    rd_expect(8'h00, 8'hA5, "R4 read returns pins");
    expect_sig(2, 8'h00, "R4 pins undriven");
    settle(1);

    // R6: three-edge input latency (rf_addr stays at data register)
    pad_in = 8'h5A;
    settle(2);
    expect_sig(0, 8'hA5, "R6 not yet visible");
    settle(1);
    expect_sig(0, 8'h5A, "R6 visible on third edge");
    settle(1);

    // R5: switch to output, preset value appears
    wr(8'hF8, 8'h00);
    settle(1);
    expect_sig(1, 8'h3C, "R5 preset driven");
    expect_sig(2, 8'hFF, "R5 drivers on");
    settle(1);
    rd_expect(8'h00, 8'h3C, "R5 preset readable");

    // R3: output register change, one edge of pin latency
    wr(8'h00, 8'hC3);
    expect_sig(1, 8'h3C, "R3 pins not same edge");
    settle(1);
    expect_sig(1, 8'hC3, "R3 pins next edge");
    settle(1);

    // R2: mixed nibble modes, upper bits dropped
    pad_in = 8'h5A;
    wr(8'hF8, 8'hE1);
    settle(1);
    expect_sig(2, 8'hF0, "R2 per-nibble oe");
    settle(1);
    rd_expect(8'h00, 8'hCA, "R2 mixed read");
    rd_expect(8'hF8, 8'h01, "R2 control bits 7:5 zero");

    // R7: open-drain outputs
    wr(8'hF8, 8'h10);
    settle(1);
    expect_sig(2, 8'h3C, "R7 open-drain oe");
    settle(1);
    rd_expect(8'h00, 8'hC3, "R7 read output register");

    // R8: address mode
    abus = 8'h96;
    wr(8'hF8, 8'h0A);
    settle(1);
    expect_sig(1, 8'h96, "R8 address driven");
    expect_sig(2, 8'hFF, "R8 address oe");
    abus = 8'h69;
    settle(1);
    expect_sig(1, 8'h69, "R8 follows bus");
    settle(1);
    rd_expect(8'h00, 8'h69, "R8 read driven address");
    wr(8'hF8, 8'h1F);
    settle(1);
    expect_sig(2, 8'hFF, "R8 open-drain ignored in address");
    settle(1);

    // R9: other addresses
    wr(8'h01, 8'h77);
    wr(8'h20, 8'h11);
    rd_expect(8'h01, 8'h00, "R9 other read zero");
    rd_expect(8'hF8, 8'h1F, "R9 control unchanged");
    wr(8'hF8, 8'h00);
    settle(1);
    expect_sig(1, 8'hC3, "R9 output register unchanged");
    settle(2);

    done = 1;
    summary();
    $finish;
  end
endmodule